// File: doc/BRIEF.md
# Fast-Page-Mode DRAM Controller

This block turns accesses from an asynchronous 16-bit processor bus into the strobe sequence that two banks of fast-page-mode DRAM need. For each bus access it decodes the bank, drives the row and then the column on a shared 10-bit multiplexed address, lowers the row strobe of the selected bank, then lowers one or both column strobes according to transfer size and the lowest address bit. It acknowledges the access as a 16-bit port.

An address bit acts as a page hint. When it is set, the row stays open after the access, and a following access to the same row only strobes the column. An access with the hint clear, or an access to another row or bank, closes the page. A free-running timer asks for a refresh at a fixed interval. The controller answers it with a refresh that lowers the column strobes before the row strobes, on both banks at once. When a refresh request and a bus access arrive on the same edge, the refresh runs first and the access is held and then served. Bus inputs are assumed synchronous to the controller clock.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is asserted, and until the first access, all row strobes, both column strobes, write enable and both acknowledges are high, and `dram_addr` is 0.
- R2: `addr[21]`=0 selects bank 0 (`ras_n[0]`) and `addr[21]`=1 selects bank 1 (`ras_n[1]`). During a bus access the other bank's row strobe stays high.
- R3: On an access that opens a row, `dram_addr` equals `addr[20:11]` in the clock where the bank's row strobe falls. The column strobe falls exactly 2 clocks later, with `dram_addr` equal to `addr[10:1]`.
- R4: A transfer is a byte when `siz_byte_n`=0 and `siz_word_n`=1, and a word otherwise. A word lowers both column strobes. A byte with `addr[0]`=0 lowers only `ucas_n`, and a byte with `addr[0]`=1 lowers only `lcas_n`.
- R5: On a write (`rd_wr_n`=0), `we_n` is low in the clock before the column strobe falls and while it is low. On a read, `we_n` is high at the column strobe. `we_n` is high whenever both row strobes are low (refresh).
- R6: While the column strobe of an access is low, `dsack_n` is 2'b01 (bit 1 low, bit 0 high). One clock after `as_n` is sampled high, `dsack_n` is 2'b11 and both column strobes are high.
- R7: An access with `addr[22]`=1 leaves its bank's row strobe low after the strobe release. The next access to the same bank and row lowers the column strobe 2 clocks after `as_n` is sampled low, and the row strobe never rises in between.
- R8: An access with `addr[22]`=0 raises its row strobe one clock after the strobe release. An access to another row or bank while a page is open first raises the open row strobe, then opens the new row.
- R9: A refresh lowers both column strobes one clock before both row strobes fall, and both column strobes are still low when the row strobes fall.
- R10: A refresh request is raised every `REF_INTERVAL` clocks and held until it is served. While bus accesses are short, successive refreshes start `REF_INTERVAL` plus or minus 24 clocks apart.
- R11: Each row strobe stays high for at least `PRE_CLKS` clocks between two low periods.
- R12: Internal reset ends two rising edges after `rst_n` rises. The first refresh request is seen at rising edge `REF_INTERVAL`+3 after `rst_n` rises. If `as_n` is first sampled low at that same edge, the refresh runs before the access's row strobe falls, and the access then completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, released synchronously inside the block |
| addr | input | 24 | Bus address: column in [10:1], row in [20:11], bank in [21], page hint in [22] |
| as_n | input | 1 | Active-low address strobe |
| siz_byte_n | input | 1 | Size bit, low for a byte transfer |
| siz_word_n | input | 1 | Size bit, low for a word transfer |
| rd_wr_n | input | 1 | High for a read, low for a write |
| ras_n | output | 2 | Active-low row strobe, one per bank |
| ucas_n | output | 1 | Active-low column strobe, upper byte lane |
| lcas_n | output | 1 | Active-low column strobe, lower byte lane |
| we_n | output | 1 | Active-low DRAM write enable |
| dsack_n | output | 2 | Active-low size acknowledge; bit 1 signals a 16-bit port |
| dram_addr | output | 10 | Multiplexed row/column address |

## Verification
The hardest case to reach from the ports is a bus strobe that lands on exactly the same edge where a refresh request first becomes visible. The refresh timer cannot be seen from outside. The bench therefore counts rising edges from reset release and lowers `as_n` so that it is first sampled on edge `REF_INTERVAL`+3. It then requires a refresh to appear before the access opens its row. A second difficulty is that a refresh can silently close an open page in the middle of random traffic. The random stimulus detects this from the row strobe it observes and switches to the row-open checks, while fresh resets keep the directed page-hit and page-miss cases clear of refresh.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ROW, ST_RAS, ST_COL, ST_CAS, ST_PAGE,
    ST_PRE, ST_RCAS, ST_RRAS, ST_REND
  } seq_st_e;

  typedef struct packed {
    logic upper;
    logic lower;
  } lane_t;
endpackage

// File: rtl/fpm_rst_sync.sv
module fpm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_sync_n = sh_q[1];
endmodule

// File: rtl/fpm_ref_timer.sv
module fpm_ref_timer #(
  parameter int INTERVAL = 390
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic pend
);
  localparam int CNT_W = $clog2(INTERVAL);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d, wrap;

  always_comb begin
    wrap   = (cnt_q == LAST);
    cnt_d  = wrap ? '0 : cnt_q + CNT_W'(1);
    pend_d = wrap | (pend_q & ~ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

  // R10: a raised request survives until the sequencer takes it
  a_r10_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !ack) |=> pend);
  // R10: the sequencer only acknowledges a request that exists
  a_r10_ack_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> pend);
endmodule

// File: rtl/fpm_lane_dec.sv
module fpm_lane_dec (
  input  logic           siz_byte_n,
  input  logic           siz_word_n,
  input  logic           a0,
  output fpm_pkg::lane_t lanes
);
  logic is_byte;

  always_comb begin
    is_byte     = !siz_byte_n && siz_word_n;
    lanes.upper = !is_byte || !a0;
    lanes.lower = !is_byte || a0;
  end

  // R4: some lane is always enabled
  always_comb a_r4_some_lane: assert (lanes.upper || lanes.lower);
endmodule

// File: rtl/fpm_seq.sv
module fpm_seq
  import fpm_pkg::*;
#(
  parameter int MUX_W    = 10,
  parameter int BANKS    = 2,
  parameter int BANK_W   = 1,
  parameter int PRE_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_n,
  input  logic              rd_wr_n,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [MUX_W-1:0]  req_row,
  input  logic [MUX_W-1:0]  req_col,
  input  logic              req_hint,
  input  lane_t             req_lanes,
  input  logic              ref_pend,
  output logic              ref_ack,
  output logic [BANKS-1:0]  ras_n,
  output logic              ucas_n,
  output logic              lcas_n,
  output logic              we_n,
  output logic [1:0]        dsack_n,
  output logic [MUX_W-1:0]  dram_addr
);
  localparam int CNT_W = $clog2(PRE_CLKS + 1);
  localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_CLKS - 1);

  seq_st_e           st_q, st_d;
  logic              cap;
  logic [BANK_W-1:0] bank_q;
  logic [MUX_W-1:0]  row_q, col_q;
  lane_t             lanes_q;
  logic              wr_q, hint_q;
  logic [CNT_W-1:0]  pre_cnt_q;
  logic              page_hit, acc_open, ref_rows;

  assign page_hit = (req_bank == bank_q) && (req_row == row_q);

  // next state
  always_comb begin
    st_d    = st_q;
    cap     = 1'b0;
    ref_ack = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (ref_pend) begin
          st_d    = ST_RCAS;
          ref_ack = 1'b1;
        end else if (!as_n) begin
          st_d = ST_ROW;
          cap  = 1'b1;
        end
      end
      ST_ROW:  st_d = ST_RAS;
      ST_RAS:  st_d = ST_COL;
      ST_COL:  st_d = ST_CAS;
      ST_CAS:  if (as_n) st_d = hint_q ? ST_PAGE : ST_PRE;
      ST_PAGE: begin
        if (ref_pend) st_d = ST_PRE;
        else if (!as_n) begin
          if (page_hit) begin
            st_d = ST_COL;
            cap  = 1'b1;
          end else begin
            st_d = ST_PRE;
          end
        end
      end
      ST_PRE:  if (pre_cnt_q == PRE_LAST) st_d = ST_IDLE;
      ST_RCAS: st_d = ST_RRAS;
      ST_RRAS: st_d = ST_REND;
      ST_REND: st_d = ST_PRE;
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      bank_q    <= '0;
      row_q     <= '0;
      col_q     <= '0;
      lanes_q   <= '0;
      wr_q      <= 1'b0;
      hint_q    <= 1'b0;
      pre_cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cap) begin
        bank_q  <= req_bank;
        row_q   <= req_row;
        col_q   <= req_col;
        lanes_q <= req_lanes;
        wr_q    <= !rd_wr_n;
        hint_q  <= req_hint;
      end
      if (st_q == ST_PRE) pre_cnt_q <= pre_cnt_q + CNT_W'(1);
      else                pre_cnt_q <= '0;
    end
  end

  // output decode
  always_comb begin
    acc_open  = (st_q == ST_RAS) || (st_q == ST_COL) ||
                (st_q == ST_CAS) || (st_q == ST_PAGE);
    ref_rows  = (st_q == ST_RRAS) || (st_q == ST_REND);
    ucas_n    = 1'b1;
    lcas_n    = 1'b1;
    if (st_q == ST_CAS) begin
      ucas_n = !lanes_q.upper;
      lcas_n = !lanes_q.lower;
    end else if ((st_q == ST_RCAS) || (st_q == ST_RRAS)) begin
      ucas_n = 1'b0;
      lcas_n = 1'b0;
    end
    we_n      = !(((st_q == ST_COL) || (st_q == ST_CAS)) && wr_q);
    dsack_n   = (st_q == ST_CAS) ? 2'b01 : 2'b11;
    dram_addr = ((st_q == ST_COL) || (st_q == ST_CAS) || (st_q == ST_PAGE))
                ? col_q : row_q;
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_ras
    assign ras_n[b] = !((acc_open && (bank_q == BANK_W'(b))) || ref_rows);

    // R11: a row strobe that rises stays high the following clock
    a_r11_ras_precharge: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n[b]) |=> ras_n[b]);
  end

  // R2: an acknowledged access has exactly one open bank
  a_r2_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    !dsack_n[1] |-> ($countones(~ras_n) == 1));
  // R6: acknowledge only with a column strobe
  a_r6_ack_with_cas: assert property (@(posedge clk) disable iff (!rst_n)
    (dsack_n == 2'b01) |-> (!ucas_n || !lcas_n));
  // R6: acknowledge is withdrawn after the strobe is seen high
  a_r6_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!dsack_n[1] && as_n) |=> dsack_n[1]);
  // R9: column strobes lead row strobes on refresh
  a_r9_cbr_order: assert property (@(posedge clk) disable iff (!rst_n)
    ((ras_n == '0) && !$past(ras_n == '0)) |-> $past(!ucas_n && !lcas_n));
  // R5: no write enable during refresh
  a_r5_we_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n == '0) |-> we_n);
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
  parameter int ADDR_W       = 24,
  parameter int MUX_W        = 10,
  parameter int BANKS        = 2,
  parameter int REF_INTERVAL = 390,
  parameter int PRE_CLKS     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              as_n,
  input  logic              siz_byte_n,
  input  logic              siz_word_n,
  input  logic              rd_wr_n,
  output logic [BANKS-1:0]  ras_n,
  output logic              ucas_n,
  output logic              lcas_n,
  output logic              we_n,
  output logic [1:0]        dsack_n,
  output logic [MUX_W-1:0]  dram_addr
);
  localparam int BANK_W   = $clog2(BANKS);
  localparam int COL_LSB  = 1;
  localparam int ROW_LSB  = COL_LSB + MUX_W;
  localparam int BANK_LSB = ROW_LSB + MUX_W;
  localparam int HINT_BIT = BANK_LSB + BANK_W;

  logic           rst_i;
  logic           ref_pend, ref_ack;
  fpm_pkg::lane_t lanes;
  logic           unused_hi;

  assign unused_hi = ^addr[ADDR_W-1:HINT_BIT+1];

  fpm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i)
  );

  fpm_ref_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
    .clk   (clk),
    .rst_n (rst_i),
    .ack   (ref_ack),
    .pend  (ref_pend)
  );

  fpm_lane_dec u_lanes (
    .siz_byte_n (siz_byte_n),
    .siz_word_n (siz_word_n),
    .a0         (addr[0]),
    .lanes      (lanes)
  );

  fpm_seq #(
    .MUX_W    (MUX_W),
    .BANKS    (BANKS),
    .BANK_W   (BANK_W),
    .PRE_CLKS (PRE_CLKS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_i),
    .as_n      (as_n),
    .rd_wr_n   (rd_wr_n),
    .req_bank  (addr[BANK_LSB +: BANK_W]),
    .req_row   (addr[ROW_LSB +: MUX_W]),
    .req_col   (addr[COL_LSB +: MUX_W]),
    .req_hint  (addr[HINT_BIT]),
    .req_lanes (lanes),
    .ref_pend  (ref_pend),
    .ref_ack   (ref_ack),
    .ras_n     (ras_n),
    .ucas_n    (ucas_n),
    .lcas_n    (lcas_n),
    .we_n      (we_n),
    .dsack_n   (dsack_n),
    .dram_addr (dram_addr)
  );
endmodule

// File: tb/fpm_dram_ctrl_bench.sv
`timescale 1ns/1ps
module fpm_dram_ctrl_bench;
  localparam int REF_INT = 390;
  localparam int PRE     = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] addr_i;
  logic        as_n, siz_byte_n, siz_word_n, rd_wr_n;
  logic [1:0]  ras_n;
  logic        ucas_n, lcas_n, we_n;
  logic [1:0]  dsack_n;
  logic [9:0]  dram_addr;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  fpm_dram_ctrl u_fpm_dram_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr_i), .as_n(as_n),
    .siz_byte_n(siz_byte_n), .siz_word_n(siz_word_n), .rd_wr_n(rd_wr_n),
    .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n), .we_n(we_n),
    .dsack_n(dsack_n), .dram_addr(dram_addr)
  );

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // expected active-low lanes {ucas_n, lcas_n}
  function automatic logic [1:0] exp_cas(input logic is_byte, input logic a0);
    if (!is_byte) return 2'b00;
    return a0 ? 2'b10 : 2'b01;
  endfunction

  // ---------------- monitor: refresh and precharge ----------------
  logic [1:0] prev_ras;
  logic [1:0] prev_cas;
  int         hi_run [2];
  int         mcyc;
  int         last_ref;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_ras  = 2'b11;
      prev_cas  = 2'b11;
      hi_run[0] = 100;
      hi_run[1] = 100;
      mcyc      = 0;
      last_ref  = -1;
    end else begin
      mcyc++;
      if (ras_n == 2'b00) chk("R5 we_n high in refresh", 32'(we_n), 32'd1);
      if (ras_n == 2'b00 && prev_ras != 2'b00) begin
        chk("R9 cas before ras", 32'(prev_cas), 32'd0);
        chk("R9 cas low at ras fall", 32'({ucas_n, lcas_n}), 32'd0);
        if (last_ref >= 0) begin
          n_cmp++;
          if (mcyc - last_ref < REF_INT - 24 || mcyc - last_ref > REF_INT + 24) begin
            n_bad++;
            $display("FAIL R10 refresh gap act=%0d exp=%0d", mcyc - last_ref, REF_INT);
          end
        end
        last_ref = mcyc;
      end
      for (int b = 0; b < 2; b++) begin
        if (ras_n[b]) hi_run[b]++;
        else begin
          if (prev_ras[b]) begin
            n_cmp++;
            if (hi_run[b] < PRE) begin
              n_bad++;
              $display("FAIL R11 precharge bank%0d act=%0d exp>=%0d", b, hi_run[b], PRE);
            end
          end
          hi_run[b] = 0;
        end
      end
      prev_ras = ras_n;
      prev_cas = {ucas_n, lcas_n};
    end
  end

  // ---------------- one bus access ----------------
  // mode 0: adaptive, 1: must hit open page, 2: must open a row
  task automatic run_access(input logic [23:0] a, input logic is_byte, input logic is_wr,
                            input int mode, input int hold, output logic ref_first);
    logic       bk;
    logic [1:0] ecas;
    logic       seen_high, got, prev_we;
    int         n, fall_at;
    bk        = a[21];
    ecas      = exp_cas(is_byte, a[0]);
    seen_high = 0;
    got       = 0;
    prev_we   = 1;
    n         = 0;
    fall_at   = -1;
    ref_first = 0;
    @(negedge clk);
    addr_i     = a;
    siz_byte_n = !is_byte;
    siz_word_n = is_byte;
    rd_wr_n    = !is_wr;
    as_n       = 1'b0;
    while (!got && n < 40) begin
      @(negedge clk);
      n++;
      if (ras_n == 2'b00 && fall_at < 0) ref_first = 1;
      if (ras_n[bk]) seen_high = 1;
      else if (seen_high && fall_at < 0 && ras_n[!bk]) begin
        fall_at = n;
        chk("R3 row address at ras fall", 32'(dram_addr), 32'(a[20:11]));
      end
      if ((!ucas_n || !lcas_n) && !ras_n[bk] && ras_n[!bk]) got = 1;
      else prev_we = we_n;
    end
    chk("R3 access reached cas", 32'(got), 32'd1);
    chk("R4 cas lanes", 32'({ucas_n, lcas_n}), 32'(ecas));
    chk("R3 column address at cas", 32'(dram_addr), 32'(a[10:1]));
    chk("R5 we_n at cas", 32'(we_n), 32'(!is_wr));
    if (is_wr) chk("R5 early write", 32'(prev_we), 32'd0);
    chk("R6 dsack at cas", 32'(dsack_n), 32'h1);
    chk("R2 other bank idle", 32'(ras_n[!bk]), 32'd1);
    if (seen_high) chk("R3 ras to cas clocks", 32'(n - fall_at), 32'd2);
    else           chk("R7 page hit latency", 32'(n), 32'd2);
    if (mode == 1) chk("R7 page stayed open", 32'(seen_high), 32'd0);
    if (mode == 2) chk("R8 row opened anew", 32'(seen_high), 32'd1);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R6 cas held with strobe", 32'({ucas_n, lcas_n}), 32'(ecas));
      chk("R6 dsack held with strobe", 32'(dsack_n), 32'h1);
    end
    as_n = 1'b1;
    @(negedge clk);
    chk("R6 dsack released", 32'(dsack_n), 32'h3);
    chk("R6 cas released", 32'({ucas_n, lcas_n}), 32'h3);
    if (a[22]) chk("R7 ras kept low", 32'(ras_n[bk]), 32'd0);
    else       chk("R8 ras precharged", 32'(ras_n[bk]), 32'd1);
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset ras", 32'(ras_n), 32'h3);
    chk("R1 reset cas", 32'({ucas_n, lcas_n}), 32'h3);
    chk("R1 reset we", 32'(we_n), 32'd1);
    chk("R1 reset dsack", 32'(dsack_n), 32'h3);
    chk("R1 reset address", 32'(dram_addr), 32'd0);
    rst_n = 1'b1;
  endtask

  function automatic logic [23:0] mk(input logic hint, input logic bank,
                                     input logic [9:0] row, input logic [9:0] col,
                                     input logic a0);
    return {1'b0, hint, bank, row, col, a0};
  endfunction

  initial begin
    logic rf;
    logic [9:0] rrow;
    rst_n = 1'b0; as_n = 1'b1; addr_i = '0;
    siz_byte_n = 1'b1; siz_word_n = 1'b1; rd_wr_n = 1'b1;
    do_reset();
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", 32'(ras_n), 32'h3);

    // directed page sequence, bank 0 (R7, R8, R4)
    run_access(mk(1, 0, 10'h123, 10'h045, 0), 0, 1, 2, 0, rf);
    run_access(mk(1, 0, 10'h123, 10'h046, 1), 1, 1, 1, 1, rf);
    run_access(mk(0, 0, 10'h123, 10'h047, 0), 1, 0, 1, 0, rf);
    // bank 1: open then miss on another row (R8, R2)
    run_access(mk(1, 1, 10'h2AA, 10'h011, 0), 0, 0, 2, 2, rf);
    run_access(mk(0, 1, 10'h155, 10'h022, 0), 1, 1, 2, 0, rf);
    // open bank 0, then access bank 1 (R8 bank miss)
    run_access(mk(1, 0, 10'h0F0, 10'h3FF, 1), 1, 0, 2, 0, rf);
    run_access(mk(0, 1, 10'h0F0, 10'h3FF, 1), 0, 0, 2, 0, rf);
    chk("R8 bank 0 closed after bank miss", 32'(ras_n[0]), 32'd1);

    // same-edge refresh priority (R12)
    do_reset();
    while (cyc != REF_INT + 1) @(negedge clk);
    run_access(mk(0, 1, 10'h3C3, 10'h155, 0), 0, 1, 2, 0, rf);
    chk("R12 refresh ran first", 32'(rf), 32'd1);

    // constrained random traffic
    void'($urandom(32'd20240611));
    for (int i = 0; i < 160; i++) begin
      rrow = ($urandom_range(0, 1) == 0) ? 10'h0A5 : 10'h35A;
      run_access(mk(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), rrow,
                    10'($urandom), 1'($urandom_range(0, 1))),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 0, $urandom_range(0, 2), rf);
    end

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule